// File: doc/BRIEF.md
# Offset-Range Floating-Point Charge Linearizer

This block turns compressed charge samples into linear charge. Each incoming 9-bit word carries a 2-bit range number, a 5-bit mantissa code and a 2-bit slot tag.

The four ranges grow by a factor of five in charge per code. They are also stacked end to end: each range begins where the range below it reaches full scale, so every range uses its whole code span. The mantissa is non-uniform. Fine bins at the low end widen as the code grows. The block reports the centre of the selected bin in units of the finest step.

A per-slot baseline, loaded through a small write port, is subtracted with a floor at zero. A calibration flag sampled with each word rescales that word's result to third-step units and is returned alongside it. Words flow through one register stage with valid/ready handshaking. A result waiting at the output is held unchanged until the consumer takes it.

Top module: `fpq_linearizer`

## Requirements
- R1: The input word is split as bits [4:0] mantissa code, bits [6:5] range number and bits [8:7] slot tag. The slot tag appears unchanged on `out_slot` with its result.
- R2: Mantissa bins have width 1 for codes 0–15, width 2 for codes 16–23 and width 4 for codes 24–31. The lower edge of code c is c, 16+2(c−16) or 32+4(c−24) respectively, and one range spans 64 steps.
- R3: Range r scales the bin by 5^r (1, 5, 25, 125) and starts at offset 0, 64, 384 or 1984 for r = 0..3. Range r therefore begins at the full-scale charge of range r−1.
- R4: The raw result is offset + (edge + width/2)·5^r, rounded with halves going up. The maximum is 9734 for range 3, code 31.
- R5: Writing `ped_val` to slot `ped_slot` with `ped_we` changes that slot's baseline from the next cycle on. A word accepted in the same cycle as the write still uses the old baseline. All baselines are zero after reset.
- R6: The slot's baseline is subtracted from the raw result, and the result is clamped to zero when the baseline exceeds it.
- R7: When `in_cal` is 1 with a word, that word's baselined result is multiplied by 3 and `out_cal` is 1; otherwise `out_cal` is 0.
- R8: A word accepted at a clock edge (`in_valid` and `in_ready` high) is presented with `out_valid` high right after that edge. If it is consumed and no new word arrives, `out_valid` falls after the next edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_charge`, `out_slot` and `out_cal` stay unchanged.
- R10: During and after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 9 | {slot, range, mantissa} |
| in_cal | input | 1 | Calibration scaling for this word |
| ped_we | input | 1 | Baseline write strobe |
| ped_slot | input | 2 | Slot whose baseline is written |
| ped_val | input | 14 | New baseline, in finest steps |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_charge | output | 18 | Linear charge |
| out_slot | output | 2 | Slot tag of the result |
| out_cal | output | 1 | Result is in third-step units |

## Verification
Two functions can meet in one cycle: a baseline write and the acceptance of a word for the same slot. The bench provokes this by raising `ped_we` and `in_valid` together for slot 3. It judges the result by requiring that this word comes out with the old baseline of zero, while the next word for slot 3 shows the new baseline. A second overlap comes from a stalled output while a new word is waiting. Here the held result must stay frozen for several cycles, and the waiting word must emerge intact only after release.

// File: rtl/fpq_lin_pkg.sv
package fpq_lin_pkg;

  localparam int unsigned MANT_W = 5;
  localparam int unsigned EXP_W  = 2;
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned NCODE  = 1 << MANT_W;
  localparam int unsigned NRANGE = 1 << EXP_W;
  localparam int unsigned RATIO  = 5;

  // bin width in finest steps: three zones, widening toward the top code
  function automatic int unsigned bin_width(input int unsigned code);
    int unsigned fine_end;
    int unsigned mid_end;
    fine_end = NCODE / 2;
    mid_end  = fine_end + NCODE / 4;
    if (code < fine_end)     return 1;
    else if (code < mid_end) return 2;
    else                     return 4;
  endfunction

  // lower edge of a code: running sum of all narrower-code widths
  function automatic int unsigned bin_edge(input int unsigned code);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < NCODE; i++)
      if (i < code) acc += bin_width(i);
    return acc;
  endfunction

  function automatic int unsigned range_span();
    return bin_edge(NCODE);
  endfunction

  function automatic int unsigned range_scale(input int unsigned r);
    int unsigned s;
    s = 1;
    for (int unsigned i = 0; i < NRANGE; i++)
      if (i < r) s *= RATIO;
    return s;
  endfunction

  // start of range r equals full scale of range r-1
  function automatic int unsigned range_offset(input int unsigned r);
    int unsigned o;
    o = 0;
    for (int unsigned i = 0; i <= NRANGE; i++)
      if (i < r) o += range_span() * range_scale(i);
    return o;
  endfunction

endpackage

// File: rtl/fpq_decode.sv
module fpq_decode
  import fpq_lin_pkg::*;
#(
  parameter int unsigned OUT_W = 18
) (
  input  logic [EXP_W-1:0]  rng,
  input  logic [MANT_W-1:0] code,
  output logic [OUT_W-1:0]  raw
);
  localparam int unsigned DBL_W = OUT_W + 1;

  logic [DBL_W-1:0] edge2_lut [NCODE];
  logic [DBL_W-1:0] off2_lut  [NRANGE];
  logic [DBL_W-1:0] scale_lut [NRANGE];

  // doubled bin centre per code: 2*edge + width
  for (genvar g = 0; g < NCODE; g++) begin : g_code
    assign edge2_lut[g] = DBL_W'(2 * bin_edge(g) + bin_width(g));
  end

  for (genvar g = 0; g < NRANGE; g++) begin : g_rng
    assign off2_lut[g]  = DBL_W'(2 * range_offset(g));
    assign scale_lut[g] = DBL_W'(range_scale(g));
  end

  logic [DBL_W-1:0] centre2;
  assign centre2 = off2_lut[rng] + DBL_W'(edge2_lut[code] * scale_lut[rng]);
  assign raw     = OUT_W'((centre2 + DBL_W'(1)) >> 1);

  always_comb begin
    if (raw > OUT_W'(range_offset(NRANGE)))
      p_raw_bound_r4 : assert (1'b0) else $error("raw result above top of range 3");
  end
endmodule

// File: rtl/fpq_baseline.sv
module fpq_baseline
  import fpq_lin_pkg::*;
#(
  parameter int unsigned OUT_W = 18,
  parameter int unsigned PED_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PED_W-1:0]  wr_val,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [OUT_W-1:0]  raw,
  output logic [OUT_W-1:0]  net,
  output logic              clamped
);
  localparam int unsigned NSLOT = 1 << SLOT_W;

  logic [PED_W-1:0] base_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  base_q[s] <= '0;
      else if (wr_en && wr_slot == SLOT_W'(s))     base_q[s] <= wr_val;
    end
  end

  logic [OUT_W-1:0] base_ext;
  assign base_ext = OUT_W'(base_q[rd_slot]);
  assign clamped  = base_ext > raw;
  assign net      = clamped ? '0 : raw - base_ext;

  p_write_lands_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base_q[$past(wr_slot)] == $past(wr_val));

  p_net_not_above_raw_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    net <= raw);
endmodule

// File: rtl/fpq_stage.sv
module fpq_stage
  import fpq_lin_pkg::*;
#(
  parameter int unsigned OUT_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OUT_W-1:0]  d_charge,
  input  logic [SLOT_W-1:0] d_slot,
  input  logic              d_cal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_charge,
  output logic [SLOT_W-1:0] out_slot,
  output logic              out_cal
);
  logic take;
  logic stall;

  assign stall    = out_valid && !out_ready;
  assign in_ready = !stall;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_charge <= '0;
      out_slot   <= '0;
      out_cal    <= 1'b0;
    end else if (!stall) begin
      out_valid <= take;
      if (take) begin
        out_charge <= d_charge;
        out_slot   <= d_slot;
        out_cal    <= d_cal;
      end
    end
  end

  p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_charge)
                                  && $stable(out_slot) && $stable(out_cal));

  p_latency_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_cal_units_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cal) |-> (out_charge % 3) == 0);
endmodule

// File: rtl/fpq_linearizer.sv
module fpq_linearizer
  import fpq_lin_pkg::*;
#(
  parameter int unsigned OUT_W = 18,
  parameter int unsigned PED_W = 14
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [SLOT_W+EXP_W+MANT_W-1:0]   in_word,
  input  logic                             in_cal,
  input  logic                             ped_we,
  input  logic [SLOT_W-1:0]                ped_slot,
  input  logic [PED_W-1:0]                 ped_val,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [OUT_W-1:0]                 out_charge,
  output logic [SLOT_W-1:0]                out_slot,
  output logic                             out_cal
);
  localparam int unsigned CAL_MUL = 3;
  localparam int unsigned TOP_RAW = range_offset(NRANGE);
  localparam int unsigned TOP_OUT = CAL_MUL * TOP_RAW;

  logic [MANT_W-1:0] f_code;
  logic [EXP_W-1:0]  f_rng;
  logic [SLOT_W-1:0] f_slot;

  assign f_code = in_word[MANT_W-1:0];
  assign f_rng  = in_word[MANT_W+EXP_W-1:MANT_W];
  assign f_slot = in_word[MANT_W+EXP_W+SLOT_W-1:MANT_W+EXP_W];

  logic [OUT_W-1:0] raw_q;
  logic [OUT_W-1:0] net_q;
  logic             clamped;
  logic [OUT_W-1:0] scaled;

  fpq_decode #(.OUT_W(OUT_W)) u_decode (
    .rng  (f_rng),
    .code (f_code),
    .raw  (raw_q)
  );

  fpq_baseline #(.OUT_W(OUT_W), .PED_W(PED_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ped_we),
    .wr_slot (ped_slot),
    .wr_val  (ped_val),
    .rd_slot (f_slot),
    .raw     (raw_q),
    .net     (net_q),
    .clamped (clamped)
  );

  assign scaled = in_cal ? OUT_W'(net_q * CAL_MUL) : net_q;

  fpq_stage #(.OUT_W(OUT_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .d_charge   (scaled),
    .d_slot     (f_slot),
    .d_cal      (in_cal),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_charge (out_charge),
    .out_slot   (out_slot),
    .out_cal    (out_cal)
  );

  p_out_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_charge <= OUT_W'(TOP_OUT));

  p_clamp_gives_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && clamped) |=> out_charge == '0);

  p_slot_follows_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_slot == $past(f_slot));
endmodule

// File: tb/sim_fpq_linearizer.sv
module sim_fpq_linearizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_word = '0;
  logic        in_cal = 1'b0;
  logic        ped_we = 1'b0;
  logic [1:0]  ped_slot = '0;
  logic [13:0] ped_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_charge;
  logic [1:0]  out_slot;
  logic        out_cal;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fpq_linearizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_cal(in_cal), .ped_we(ped_we), .ped_slot(ped_slot),
    .ped_val(ped_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_charge(out_charge), .out_slot(out_slot), .out_cal(out_cal)
  );

  // columns: cal, slot, range, code, expected charge (hand-computed bin centres)
  localparam int unsigned VEC [12][5] = '{
    '{0, 0, 0,  0,     1},
    '{0, 1, 0, 15,    16},
    '{0, 2, 0, 16,    17},
    '{0, 3, 0, 31,    62},
    '{0, 0, 1,  0,    67},
    '{0, 1, 1, 31,   374},
    '{0, 2, 2,  8,   597},
    '{0, 3, 2, 20,  1009},
    '{0, 0, 3,  0,  2047},
    '{0, 1, 3, 31,  9734},
    '{1, 2, 1,  0,   201},
    '{1, 3, 3, 31, 29202}
  };

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] s, input logic [1:0] r, input logic [4:0] m,
                      input logic c, input logic pw, input logic [13:0] pv);
    @(negedge clk);
    in_valid = 1'b1; in_word = {s, r, m}; in_cal = c;
    ped_we = pw; ped_slot = s; ped_val = pv;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; ped_we = 1'b0;
  endtask

  task automatic set_base(input logic [1:0] s, input logic [13:0] v);
    @(negedge clk);
    ped_we = 1'b1; ped_slot = s; ped_val = v;
    @(posedge clk);
    @(negedge clk);
    ped_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid in reset", out_valid, 0);
    chk("R10 in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", out_valid, 0);

    // R1 R2 R3 R4 R7: table walk, baselines still zero (R5 reset value)
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][1][1:0], VEC[i][2][1:0], VEC[i][3][4:0], VEC[i][0][0], 1'b0, '0);
      chk("R8 out_valid after accept", out_valid, 1);
      chk("R4 charge", out_charge, VEC[i][4]);
      chk("R1 slot", out_slot, VEC[i][1]);
      chk("R7 cal flag", out_cal, VEC[i][0]);
    end
    @(negedge clk);
    chk("R8 out_valid falls when drained", out_valid, 0);

    // R5 R6: baselines
    set_base(2'd1, 14'd10);
    set_base(2'd2, 14'd100);
    send(2'd2, 2'd1, 5'd0, 1'b0, 1'b0, '0);
    chk("R6 clamp to zero", out_charge, 0);
    send(2'd1, 2'd1, 5'd31, 1'b0, 1'b0, '0);
    chk("R5 baseline subtracted", out_charge, 364);
    send(2'd1, 2'd1, 5'd31, 1'b1, 1'b0, '0);
    chk("R7 cal after baseline", out_charge, 1092);
    send(2'd0, 2'd3, 5'd0, 1'b0, 1'b0, '0);
    chk("R5 other slot untouched", out_charge, 2047);

    // R5: write and accept for the same slot in one cycle
    send(2'd3, 2'd0, 5'd31, 1'b0, 1'b1, 14'd50);
    chk("R5 same-cycle uses old baseline", out_charge, 62);
    send(2'd3, 2'd0, 5'd31, 1'b0, 1'b0, '0);
    chk("R5 next word uses new baseline", out_charge, 12);

    // R9: stall with a waiting word
    @(negedge clk); out_ready = 1'b0;
    send(2'd1, 2'd1, 5'd31, 1'b0, 1'b0, '0);
    in_valid = 1'b1; in_word = {2'd0, 2'd0, 5'd0}; in_cal = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 held valid", out_valid, 1);
      chk("R9 held charge", out_charge, 364);
      chk("R9 held slot", out_slot, 1);
      chk("R9 in_ready low", in_ready, 0);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R9 waiting word after release", out_charge, 1);
    chk("R1 waiting word slot", out_slot, 0);
    @(posedge clk); @(negedge clk);
    chk("R8 drained", out_valid, 0);

    finish_run();
  end
endmodule